// File: doc/BRIEF.md
# Character LCD Message Sequencer

This block drives a two-line, sixteen-column character display over an 8-bit parallel write-only bus. Each byte goes out with a strobe and a select line that marks it as either a command or a character. Busy polling is not used, so every step is paced by counted delays.

After reset the block waits through a power-up interval. It then sends the display configuration commands and places the cursor at the start of the top row. It writes the sixteen characters `FPGAs are fun!!!` there, moves the cursor to the start of the bottom row and writes `--`. From then on it issues a shift-whole-display-left command at a programmable interval, without end, so the text scrolls. A status flag tells the rest of the chip when both rows have been written.

All timing is given in clock cycles. A user sets the parameters for the system clock so that each delay meets the display controller's minimum.

Top module: `char_lcd_sequencer`

## Requirements
- R1: No strobe pulse appears before at least POWERUP_CYC clock cycles have passed since reset was released.
- R2: The first four bytes are commands (`bus_is_char` = 0), in this order: 0x38 (8-bit bus, two rows, 5x7 font), 0x0C (display on, cursor hidden), 0x06 (address increments, no display shift), 0x01 (clear).
- R3: The next byte is command 0x80 (cursor to top row, column 0). It is followed by the sixteen ASCII bytes of `FPGAs are fun!!!` in string order, each with `bus_is_char` = 1.
- R4: The next byte is command 0xC0 (cursor to bottom row, column 0). It is followed by two ASCII bytes 0x2D (`-`), each with `bus_is_char` = 1.
- R5: Every byte after those 24 is command 0x18 (shift whole display left), with `bus_is_char` = 0. This repeats for as long as reset stays low.
- R6: `bus_data` and `bus_is_char` settle at least SETUP_CYC cycles before `bus_strobe` rises and stay unchanged while it is high. `bus_strobe` stays high for exactly PULSE_CYC cycles.
- R7: After an ordinary command or character byte, the next strobe rises no earlier than HOLD_CYC + SHORT_CYC cycles after the previous strobe fell.
- R8: After the clear command (0x01), the next strobe rises no earlier than HOLD_CYC + LONG_CYC cycles after the fall.
- R9: After a shift command (0x18), the next strobe rises no earlier than HOLD_CYC + SCROLL_CYC cycles after the fall.
- R10: `msg_done` is low from reset until the first 0x18 command is placed on the bus. It is high from that cycle on, and it never drops while reset stays low.
- R11: While reset is high, `bus_strobe` and `msg_done` are low. When reset is released, at any point in a run, the whole sequence restarts from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | output | 8 | Command or character byte |
| bus_strobe | output | 1 | Write strobe; the display latches the byte on its falling edge |
| bus_is_char | output | 1 | 0 = command, 1 = character data |
| msg_done | output | 1 | High once both rows are written and scrolling has begun |

## Verification
The bench builds the block with delays of only tens of cycles: 40 for power-up, 3-cycle pulses, 2-cycle setup, 6 and 25 cycles for the short and clear waits, and 50 between scroll commands. This lets a full pass through configuration, both rows and several scroll steps finish in a few hundred cycles. It also makes each delay distinct, so a wait picked for the wrong byte shows up as a gap error. With these values the bench can afford a reset at a random point in mid-run followed by a complete run, which checks the restart as well as every byte, select value, pulse width and gap against a stream worked out from the requirements.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   typedef enum logic [1:0] {
      WAIT_SHORT  = 2'd0,
      WAIT_LONG   = 2'd1,
      WAIT_SCROLL = 2'd2
   } wait_sel_t;

   typedef struct packed {
      logic      is_char;
      logic [7:0] code;
      wait_sel_t wait_sel;
   } seq_step_t;

   localparam logic [7:0] OP_CONFIG   = 8'h38;
   localparam logic [7:0] OP_SHOW     = 8'h0C;
   localparam logic [7:0] OP_ENTRY    = 8'h06;
   localparam logic [7:0] OP_WIPE     = 8'h01;
   localparam logic [7:0] OP_ROW_TOP  = 8'h80;
   localparam logic [7:0] OP_ROW_LOW  = 8'hC0;
   localparam logic [7:0] OP_SLIDE_L  = 8'h18;

   localparam int TOP_LEN = 16;
   localparam int LOW_LEN = 2;
   localparam logic [8*TOP_LEN-1:0] TOP_TEXT = "FPGAs are fun!!!";
   localparam logic [8*LOW_LEN-1:0] LOW_TEXT = "--";

   // step layout: 4 setup commands, top cursor, top text, low cursor, low text
   localparam int TOP_CUR  = 4;
   localparam int TOP_BASE = TOP_CUR + 1;
   localparam int LOW_CUR  = TOP_BASE + TOP_LEN;
   localparam int LOW_BASE = LOW_CUR + 1;
   localparam int N_STEPS  = LOW_BASE + LOW_LEN;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/lcd_script_rom.sv
module lcd_script_rom
   import lcd_seq_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] idx,
   output seq_step_t        step
);

   always_comb begin
      int i;
      i = int'(idx);
      step = '{is_char: 1'b0, code: OP_SLIDE_L, wait_sel: WAIT_SCROLL};
      if (i == 0)
         step = '{is_char: 1'b0, code: OP_CONFIG, wait_sel: WAIT_SHORT};
      else if (i == 1)
         step = '{is_char: 1'b0, code: OP_SHOW, wait_sel: WAIT_SHORT};
      else if (i == 2)
         step = '{is_char: 1'b0, code: OP_ENTRY, wait_sel: WAIT_SHORT};
      else if (i == 3)
         step = '{is_char: 1'b0, code: OP_WIPE, wait_sel: WAIT_LONG};
      else if (i == TOP_CUR)
         step = '{is_char: 1'b0, code: OP_ROW_TOP, wait_sel: WAIT_SHORT};
      else if (i >= TOP_BASE && i < LOW_CUR)
         step = '{is_char: 1'b1,
                  code: TOP_TEXT[8*(TOP_LEN-1-(i-TOP_BASE)) +: 8],
                  wait_sel: WAIT_SHORT};
      else if (i == LOW_CUR)
         step = '{is_char: 1'b0, code: OP_ROW_LOW, wait_sel: WAIT_SHORT};
      else if (i >= LOW_BASE && i < N_STEPS)
         step = '{is_char: 1'b1,
                  code: LOW_TEXT[8*(LOW_LEN-1-(i-LOW_BASE)) +: 8],
                  wait_sel: WAIT_SHORT};
   end

endmodule

// File: rtl/lcd_byte_writer.sv
module lcd_byte_writer
   import lcd_seq_pkg::*;
#(
   parameter int SETUP_CYC  = 2,
   parameter int PULSE_CYC  = 12,
   parameter int HOLD_CYC   = 2,
   parameter int SHORT_CYC  = 2000,
   parameter int LONG_CYC   = 82000,
   parameter int SCROLL_CYC = 15000000
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      start,
   input  seq_step_t step_in,
   output logic      busy,
   output logic [7:0] data_o,
   output logic      strobe_o,
   output logic      is_char_o
);

   localparam int CNT_MAX = max3(max3(SETUP_CYC, PULSE_CYC, HOLD_CYC),
                                 max3(SHORT_CYC, LONG_CYC, SCROLL_CYC), 1);
   localparam int CW = $clog2(CNT_MAX + 1);

   typedef enum logic [2:0] {
      PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD, PH_SETTLE
   } phase_t;

   phase_t      phase;
   logic [CW-1:0] cnt;
   wait_sel_t   wait_q;
   logic [CW-1:0] settle_load;

   always_comb begin
      unique case (wait_q)
         WAIT_LONG:   settle_load = CW'(LONG_CYC - 1);
         WAIT_SCROLL: settle_load = CW'(SCROLL_CYC - 1);
         default:     settle_load = CW'(SHORT_CYC - 1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         wait_q    <= WAIT_SHORT;
         data_o    <= '0;
         is_char_o <= 1'b0;
         strobe_o  <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               data_o    <= step_in.code;
               is_char_o <= step_in.is_char;
               wait_q    <= step_in.wait_sel;
               cnt       <= CW'(SETUP_CYC - 1);
               phase     <= PH_SETUP;
            end
            PH_SETUP: if (cnt == '0) begin
               strobe_o <= 1'b1;
               cnt      <= CW'(PULSE_CYC - 1);
               phase    <= PH_PULSE;
            end else cnt <= cnt - 1'b1;
            PH_PULSE: if (cnt == '0) begin
               strobe_o <= 1'b0;
               cnt      <= CW'(HOLD_CYC - 1);
               phase    <= PH_HOLD;
            end else cnt <= cnt - 1'b1;
            PH_HOLD: if (cnt == '0) begin
               cnt   <= settle_load;
               phase <= PH_SETTLE;
            end else cnt <= cnt - 1'b1;
            PH_SETTLE: if (cnt == '0) phase <= PH_IDLE;
                       else cnt <= cnt - 1'b1;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/char_lcd_sequencer.sv
module char_lcd_sequencer
   import lcd_seq_pkg::*;
#(
   parameter int POWERUP_CYC = 750000,
   parameter int SETUP_CYC   = 2,
   parameter int PULSE_CYC   = 12,
   parameter int HOLD_CYC    = 2,
   parameter int SHORT_CYC   = 2000,
   parameter int LONG_CYC    = 82000,
   parameter int SCROLL_CYC  = 15000000
) (
   input  logic       clk,
   input  logic       rst,
   output logic [7:0] bus_data,
   output logic       bus_strobe,
   output logic       bus_is_char,
   output logic       msg_done
);

   localparam int IDX_W = $clog2(N_STEPS + 1);
   localparam int PW    = $clog2(POWERUP_CYC + 1);

   if (POWERUP_CYC < 1 || SETUP_CYC < 1 || PULSE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_strobe
      $error("char_lcd_sequencer: strobe and power-up counts must be at least 1");
   end
   if (SHORT_CYC < 1 || LONG_CYC < SHORT_CYC || SCROLL_CYC < 1) begin : g_bad_wait
      $error("char_lcd_sequencer: waits must be positive and LONG_CYC >= SHORT_CYC");
   end

   logic [PW-1:0]    pwr_cnt;
   logic             pwr_done;
   logic [IDX_W-1:0] idx;
   logic             busy;
   logic             start;
   seq_step_t        step;

   always_ff @(posedge clk) begin
      if (rst) begin
         pwr_cnt  <= '0;
         pwr_done <= 1'b0;
      end else if (!pwr_done) begin
         pwr_cnt  <= pwr_cnt + 1'b1;
         pwr_done <= (pwr_cnt == PW'(POWERUP_CYC - 1));
      end
   end

   assign start = pwr_done && !busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx      <= '0;
         msg_done <= 1'b0;
      end else if (start) begin
         if (idx != IDX_W'(N_STEPS)) idx <= idx + 1'b1;
         else                        msg_done <= 1'b1;
      end
   end

   lcd_script_rom #(.IDX_W(IDX_W)) u_rom (
      .idx  (idx),
      .step (step)
   );

   lcd_byte_writer #(
      .SETUP_CYC (SETUP_CYC),
      .PULSE_CYC (PULSE_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .SHORT_CYC (SHORT_CYC),
      .LONG_CYC  (LONG_CYC),
      .SCROLL_CYC(SCROLL_CYC)
   ) u_writer (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .step_in  (step),
      .busy     (busy),
      .data_o   (bus_data),
      .strobe_o (bus_strobe),
      .is_char_o(bus_is_char)
   );

endmodule

// File: rtl/char_lcd_sequencer_chk.sv
module char_lcd_sequencer_chk #(
   parameter int POWERUP_CYC = 750000,
   parameter int PULSE_CYC   = 12
) (
   input logic       clk,
   input logic       rst,
   input logic [7:0] bus_data,
   input logic       bus_strobe,
   input logic       bus_is_char,
   input logic       msg_done
);

   int unsigned since_rst;
   int unsigned high_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_rst <= 0;
         high_run  <= 0;
      end else begin
         if (since_rst < POWERUP_CYC) since_rst <= since_rst + 1;
         high_run <= bus_strobe ? high_run + 1 : 0;
      end
   end

   // R1
   powerup_wait_chk: assert property (@(posedge clk) disable iff (rst)
      bus_strobe |-> (since_rst >= POWERUP_CYC));

   // R6
   strobe_rise_setup_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_strobe) |-> ($stable(bus_data) && $stable(bus_is_char)));

   // R6
   strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_strobe && $past(bus_strobe)) |-> ($stable(bus_data) && $stable(bus_is_char)));

   // R6
   strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
      bus_strobe |-> (high_run < PULSE_CYC));

   // R10
   done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      msg_done |=> msg_done);

   // R5
   scroll_cmd_only_chk: assert property (@(posedge clk) disable iff (rst)
      msg_done |-> (!bus_is_char && bus_data == 8'h18));

endmodule

bind char_lcd_sequencer char_lcd_sequencer_chk #(
   .POWERUP_CYC(POWERUP_CYC),
   .PULSE_CYC  (PULSE_CYC)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .bus_data   (bus_data),
   .bus_strobe (bus_strobe),
   .bus_is_char(bus_is_char),
   .msg_done   (msg_done)
);

// File: tb/tb_char_lcd_sequencer.sv
`timescale 1ns/1ps
module tb_char_lcd_sequencer;

   localparam int P_PWR    = 40;
   localparam int P_SETUP  = 2;
   localparam int P_PULSE  = 3;
   localparam int P_HOLD   = 1;
   localparam int P_SHORT  = 6;
   localparam int P_LONG   = 25;
   localparam int P_SCROLL = 50;
   localparam int N_WANT   = 28;
   localparam int WDOG     = 20000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] bus_data;
   logic       bus_strobe;
   logic       bus_is_char;
   logic       msg_done;

   always #2 clk = ~clk;

   char_lcd_sequencer #(
      .POWERUP_CYC(P_PWR), .SETUP_CYC(P_SETUP), .PULSE_CYC(P_PULSE),
      .HOLD_CYC(P_HOLD), .SHORT_CYC(P_SHORT), .LONG_CYC(P_LONG),
      .SCROLL_CYC(P_SCROLL)
   ) dut (
      .clk(clk), .rst(rst), .bus_data(bus_data), .bus_strobe(bus_strobe),
      .bus_is_char(bus_is_char), .msg_done(msg_done)
   );

   int n_chk  = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // expected {is_char, byte} for position k of the stream
   function automatic logic [8:0] exp_byte(input int k);
      string top;
      top = "FPGAs are fun!!!";
      if (k == 0) return {1'b0, 8'h38};
      if (k == 1) return {1'b0, 8'h0C};
      if (k == 2) return {1'b0, 8'h06};
      if (k == 3) return {1'b0, 8'h01};
      if (k == 4) return {1'b0, 8'h80};
      if (k >= 5 && k <= 20) return {1'b1, top[k-5]};
      if (k == 21) return {1'b0, 8'hC0};
      if (k == 22 || k == 23) return {1'b1, 8'h2D};
      return {1'b0, 8'h18};
   endfunction

   function automatic string req_of(input int k);
      if (k <= 3)  return "R2";
      if (k <= 20) return "R3";
      if (k <= 23) return "R4";
      return "R5";
   endfunction

   function automatic int min_gap(input logic [8:0] prev);
      if (prev == {1'b0, 8'h01}) return P_HOLD + P_LONG;
      if (prev == {1'b0, 8'h18}) return P_HOLD + P_SCROLL;
      return P_HOLD + P_SHORT;
   endfunction

   // monitor state
   int         cyc = 0;
   int         k_seen = 0;
   int         rise_cyc, fall_cyc, chg_cyc;
   logic       prev_e = 1'b0;
   logic [8:0] prev_bus = '0;
   logic [8:0] last_byte = '0;

   always @(negedge clk) begin
      if (rst) begin
         cyc = 0; k_seen = 0; chg_cyc = 0; prev_e = 1'b0;
         prev_bus = {bus_is_char, bus_data};
      end else begin
         cyc++;
         if ({bus_is_char, bus_data} != prev_bus) begin
            // R6 no change while strobe high
            if (prev_e && bus_strobe)
               check(1'b0, "R6 bus changed under strobe", int'({bus_is_char, bus_data}), int'(prev_bus));
            chg_cyc = cyc;
         end
         if (bus_strobe && !prev_e) begin
            rise_cyc = cyc;
            check(cyc - chg_cyc >= P_SETUP, "R6 setup", cyc - chg_cyc, P_SETUP);
            if (k_seen == 0)
               check(cyc >= P_PWR, "R1 power-up wait", cyc, P_PWR);
            else if (k_seen > 24)
               check(cyc - fall_cyc >= min_gap(last_byte), "R9 scroll gap", cyc - fall_cyc, min_gap(last_byte));
            else if (last_byte == {1'b0, 8'h01})
               check(cyc - fall_cyc >= min_gap(last_byte), "R8 clear gap", cyc - fall_cyc, min_gap(last_byte));
            else
               check(cyc - fall_cyc >= min_gap(last_byte), "R7 short gap", cyc - fall_cyc, min_gap(last_byte));
         end
         if (!bus_strobe && prev_e) begin
            fall_cyc = cyc;
            last_byte = prev_bus;
            check(cyc - rise_cyc == P_PULSE, "R6 pulse width", cyc - rise_cyc, P_PULSE);
            check(prev_bus == exp_byte(k_seen), req_of(k_seen), int'(prev_bus), int'(exp_byte(k_seen)));
            check(msg_done == (k_seen >= 24), "R10 done flag", int'(msg_done), int'(k_seen >= 24));
            k_seen++;
         end
         prev_e = bus_strobe;
         prev_bus = {bus_is_char, bus_data};
      end
   end

   initial begin
      int first_run;
      int rlen;
      int t;
      void'($urandom(32'd20917));
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(!bus_strobe, "R11 strobe low in reset", int'(bus_strobe), 0);
      check(!msg_done, "R11 done low in reset", int'(msg_done), 0);
      rst = 1'b0;
      // random mid-run restart point
      first_run = 60 + int'($urandom % 250);
      repeat (first_run) @(negedge clk);
      rst = 1'b1;
      rlen = 1 + int'($urandom % 4);
      repeat (rlen) @(negedge clk);
      check(!bus_strobe, "R11 strobe low in mid-run reset", int'(bus_strobe), 0);
      check(!msg_done, "R11 done low in mid-run reset", int'(msg_done), 0);
      rst = 1'b0;
      t = 0;
      while (k_seen < N_WANT && t < WDOG) begin
         @(negedge clk);
         t++;
      end
      if (t >= WDOG) check(1'b0, "R5 watchdog expired", k_seen, N_WANT);
      check(msg_done, "R10 done after scroll", int'(msg_done), 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule